// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Interface

This block is the external bus front end of an 8-bit controller whose memory sits off chip behind a time-shared bus. It divides the oscillator clock by four to make the bus clock E. Each E period is split into four oscillator-cycle quarters. In the first quarter an address strobe is raised, and the shared 8-bit port carries the low byte of the address. A dedicated port carries the high address byte for the whole period. In the second half, while E is high, the shared port carries write data or is released so that memory can return read data.

A latch on the board side is modelled inside the block. It is transparent while the strobe is high and holds its value once the strobe falls, so external memory sees a stable 16-bit address for the rest of the period. A requester inside the chip presents an address, write data and a direction flag. The block takes that request at the start of an E period and acknowledges it. A read returns its byte on a separate path. When the stop input is high, E and the strobe are frozen low at the end of the current period.

Top module: `mxbus_if`

## Requirements
- R1: While running, e_clk is low for two oscillator cycles and then high for two, so one E period lasts four oscillator cycles.
- R2: as_strobe is high for exactly one oscillator cycle in every running E period, including idle periods. That cycle is the first quarter, while e_clk is low.
- R3: addr_hi_port carries bits 15..8 of the active address for the whole E period.
- R4: During the strobe quarter, mux_oe is 1 and mux_out carries bits 7..0 of the address.
- R5: In the second quarter (strobe low, E low), mux_oe is 0. On a write, mux_oe is 1 and mux_out carries the write data only during the two quarters in which e_clk is high.
- R6: On a read, mux_oe stays 0 while e_clk is high. mux_in is sampled at the oscillator edge where e_clk falls. That byte appears on rd_data, with rd_valid high for the one oscillator cycle that follows this edge.
- R7: mem_addr equals the active address from the strobe quarter through the end of the E period, and it does not change while as_strobe is low.
- R8: A request is taken only at the start of an E period. req_ack is high for one cycle together with as_strobe. With req_valid low, the period is idle: req_ack stays 0, the previous address is repeated, the shared port is not driven while E is high, and no read completes.
- R9: If stop_in is high at the end of an E period, e_clk, as_strobe and mux_oe stay 0, and no request is acknowledged, for as long as stop_in stays high. After stop_in falls, the strobe quarter begins on the next oscillator edge.
- R10: During reset, e_clk, as_strobe, mux_oe, req_ack and rd_valid are 0. The first E period starts at the first oscillator edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_in | input | 1 | Low-power stop request; halts E at the end of the period |
| req_valid | input | 1 | Internal bus request pending |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | Request taken (strobe quarter) |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | rd_data is valid this cycle |
| e_clk | output | 1 | Bus clock E |
| as_strobe | output | 1 | Address strobe |
| addr_hi_port | output | 8 | High address byte pins |
| mux_out | output | 8 | Shared port output value |
| mux_oe | output | 1 | Shared port output enable |
| mux_in | input | 8 | Shared port input value |
| mem_addr | output | 16 | Demultiplexed address seen by external memory |

## Verification
All outputs are registered, so the state of a quarter is visible one oscillator edge after that quarter begins. The bench always waits for as_strobe, and from that point it checks one quarter per falling clock edge: strobe and acknowledge in the first, release in the second, and E high with write data or a released port in the third and fourth. A read's byte is due on the edge that ends the fourth quarter, so rd_valid is checked at the next falling edge. That is the following strobe quarter, or the first halted cycle when a stop follows. Resumption after a stop and after reset is due exactly one edge after the controlling input falls, and the bench counts the edges it waits to confirm this.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
  // Quarters of one E period, one oscillator cycle each.
  typedef enum logic [1:0] {
    Q_STRB = 2'd0,  // strobe high, low address on shared port
    Q_TURN = 2'd1,  // strobe low, port released
    Q_DLO  = 2'd2,  // E high, first data quarter
    Q_DHI  = 2'd3   // E high, last data quarter; E falls at its end
  } quarter_e;

  localparam int unsigned QUARTERS = 4;
endpackage

// File: rtl/mxbus_quarter_gen.sv
module mxbus_quarter_gen
  import mxbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     stop_in,
  output quarter_e nxt_q,
  output logic     nxt_halted,
  output logic     cyc_start,
  output logic     cyc_end
);
  quarter_e q;
  logic     halted;
  logic     boundary;

  assign boundary   = halted || (q == Q_DHI);
  assign cyc_end    = !halted && (q == Q_DHI);
  assign cyc_start  = boundary && !stop_in;
  assign nxt_halted = boundary ? stop_in : 1'b0;

  always_comb begin
    if (boundary) nxt_q = stop_in ? Q_DHI : Q_STRB;
    else          nxt_q = quarter_e'(q + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b1;
      q      <= Q_DHI;
    end else begin
      halted <= nxt_halted;
      q      <= nxt_q;
    end
  end
endmodule

// File: rtl/mxbus_pin_seq.sv
module mxbus_pin_seq
  import mxbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  quarter_e          nxt_q,
  input  logic              nxt_halted,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mux_in,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              e_clk,
  output logic              as_strobe,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] mux_out,
  output logic              mux_oe
);
  logic              cur_valid, cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  logic              n_valid, n_write, take;
  logic [ADDR_W-1:0] n_addr;
  logic [DATA_W-1:0] n_wdata;
  logic              n_strb, n_data;

  assign take    = cyc_start && req_valid;
  assign n_valid = cyc_start ? req_valid : (cyc_end ? 1'b0 : cur_valid);
  assign n_write = take ? req_write : cur_write;
  assign n_addr  = take ? req_addr  : cur_addr;
  assign n_wdata = take ? req_wdata : cur_wdata;
  assign n_strb  = !nxt_halted && (nxt_q == Q_STRB);
  assign n_data  = !nxt_halted && ((nxt_q == Q_DLO) || (nxt_q == Q_DHI));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      cur_write <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      req_ack   <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      e_clk     <= 1'b0;
      as_strobe <= 1'b0;
      addr_hi   <= '0;
      mux_out   <= '0;
      mux_oe    <= 1'b0;
    end else begin
      cur_valid <= n_valid;
      cur_write <= n_write;
      cur_addr  <= n_addr;
      cur_wdata <= n_wdata;
      req_ack   <= take;
      e_clk     <= n_data;
      as_strobe <= n_strb;
      addr_hi   <= n_addr[ADDR_W-1:DATA_W];
      rd_valid  <= cyc_end && cur_valid && !cur_write;
      if (cyc_end && cur_valid && !cur_write) rd_data <= mux_in;
      if (n_strb) begin
        mux_out <= n_addr[DATA_W-1:0];
        mux_oe  <= 1'b1;
      end else if (n_data && n_valid && n_write) begin
        mux_out <= n_wdata;
        mux_oe  <= 1'b1;
      end else begin
        mux_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mxbus_addr_latch.sv
module mxbus_addr_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  // Transparent while le is high, holds the last value once le drops.
  assign q = le ? d : held;

  always_ff @(posedge clk) begin
    if (rst)     held <= '0;
    else if (le) held <= d;
  end
endmodule

// File: rtl/mxbus_if.sv
module mxbus_if
  import mxbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_in,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              e_clk,
  output logic              as_strobe,
  output logic [HI_W-1:0]   addr_hi_port,
  output logic [DATA_W-1:0] mux_out,
  output logic              mux_oe,
  input  logic [DATA_W-1:0] mux_in,
  output logic [ADDR_W-1:0] mem_addr
);
  quarter_e          nxt_q;
  logic              nxt_halted, cyc_start, cyc_end;
  logic [DATA_W-1:0] bus_pins;
  logic [DATA_W-1:0] lo_addr;

  mxbus_quarter_gen u_qgen (
    .clk        (clk),
    .rst        (rst),
    .stop_in    (stop_in),
    .nxt_q      (nxt_q),
    .nxt_halted (nxt_halted),
    .cyc_start  (cyc_start),
    .cyc_end    (cyc_end)
  );

  mxbus_pin_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .nxt_q      (nxt_q),
    .nxt_halted (nxt_halted),
    .cyc_start  (cyc_start),
    .cyc_end    (cyc_end),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .mux_in     (mux_in),
    .req_ack    (req_ack),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .e_clk      (e_clk),
    .as_strobe  (as_strobe),
    .addr_hi    (addr_hi_port),
    .mux_out    (mux_out),
    .mux_oe     (mux_oe)
  );

  // Value present on the shared pins: own drive when enabled, else external.
  assign bus_pins = mux_oe ? mux_out : mux_in;

  mxbus_addr_latch #(.W(DATA_W)) u_lat (
    .clk (clk),
    .rst (rst),
    .le  (as_strobe),
    .d   (bus_pins),
    .q   (lo_addr)
  );

  assign mem_addr = {addr_hi_port, lo_addr};
endmodule

// File: rtl/mxbus_if_chk.sv
module mxbus_if_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_in,
  input logic              e_clk,
  input logic              as_strobe,
  input logic              mux_oe,
  input logic              req_ack,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr
);
  p_e_two_high_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(e_clk) |=> e_clk);
  p_e_drops_r1: assert property (@(posedge clk) disable iff (rst)
    (e_clk && $past(e_clk)) |=> !e_clk);
  p_strb_e_low_r2: assert property (@(posedge clk) disable iff (rst)
    as_strobe |-> !e_clk);
  p_strb_single_r2: assert property (@(posedge clk) disable iff (rst)
    as_strobe |=> !as_strobe);
  p_strb_follows_e_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(e_clk) && !$past(stop_in)) |-> as_strobe);
  p_turn_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(as_strobe) |-> !mux_oe);
  p_rd_after_efall_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!e_clk && $past(e_clk)));
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !as_strobe |-> $stable(mem_addr));
  p_ack_with_strb_r8: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> as_strobe);
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_in && !e_clk && !as_strobe && !$past(as_strobe))
      |=> (!e_clk && !as_strobe && !mux_oe && !req_ack));
endmodule

bind mxbus_if mxbus_if_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_in   (stop_in),
  .e_clk     (e_clk),
  .as_strobe (as_strobe),
  .mux_oe    (mux_oe),
  .req_ack   (req_ack),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr)
);

// File: tb/mxbus_if_bench.sv
module mxbus_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst, stop_in, req_valid, req_write;
  logic [15:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rd_data, addr_hi_port, mux_out, mux_in;
  logic        req_ack, rd_valid, e_clk, as_strobe, mux_oe;

  int          total = 0;
  int          fails = 0;
  logic        pend_rd = 1'b0;
  logic [7:0]  pend_dat = '0;
  logic [15:0] last_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxbus_if u_mxbus_if (
    .clk(clk), .rst(rst), .stop_in(stop_in), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_ack(req_ack), .rd_data(rd_data), .rd_valid(rd_valid),
    .e_clk(e_clk), .as_strobe(as_strobe), .addr_hi_port(addr_hi_port),
    .mux_out(mux_out), .mux_oe(mux_oe), .mux_in(mux_in), .mem_addr(mem_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one E period; entered at the falling edge before the strobe quarter.
  task automatic do_cycle(input logic v, input logic w, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] rd, output int waited);
    logic [15:0] ea;
    ea = v ? a : last_addr;
    req_valid = v; req_write = w; req_addr = a; req_wdata = wd;
    waited = 0;
    do begin @(negedge clk); waited++; end while (!as_strobe && waited < 20);
    chk("R2 strobe in first quarter", as_strobe, 1);
    chk("R1 e low in strobe quarter", e_clk, 0);
    chk("R8 ack", req_ack, v);
    chk("R4 port enabled", mux_oe, 1);
    chk("R4 low address", mux_out, ea[7:0]);
    chk("R3 high address", addr_hi_port, ea[15:8]);
    chk("R7 latched address", mem_addr, ea);
    chk("R6 rd_valid", rd_valid, pend_rd);
    if (pend_rd) chk("R6 rd_data", rd_data, pend_dat);
    req_valid = 0;
    mux_in = 8'hA5;
    pend_rd = v && !w;
    pend_dat = rd;
    @(negedge clk);
    chk("R2 strobe low after one cycle", as_strobe, 0);
    chk("R1 e low second quarter", e_clk, 0);
    chk("R5 released in turn quarter", mux_oe, 0);
    chk("R7 address held", mem_addr, ea);
    if (v && !w) mux_in = rd;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R1 e high", e_clk, 1);
      chk("R2 strobe low", as_strobe, 0);
      chk("R5 R6 R8 data drive", mux_oe, v && w);
      if (v && w) chk("R5 write data", mux_out, wd);
      chk("R7 address held in data phase", mem_addr, ea);
      chk("R3 high address held", addr_hi_port, ea[15:8]);
    end
    last_addr = ea;
  endtask

  initial begin
    int wt;
    rst = 1; stop_in = 0; req_valid = 0; req_write = 0;
    req_addr = '0; req_wdata = '0; mux_in = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R10 e in reset", e_clk, 0);
    chk("R10 strobe in reset", as_strobe, 0);
    chk("R10 oe in reset", mux_oe, 0);
    chk("R10 ack in reset", req_ack, 0);
    chk("R10 rd_valid in reset", rd_valid, 0);
    rst = 0;
    do_cycle(1, 1, 16'h12C4, 8'h3C, 8'h00, wt);
    chk("R10 first period right after reset", wt, 1);

    for (int i = 0; i < 40; i++)
      do_cycle(1, 1, 16'(i * 16'h0B3D + 16'h1E0F), 8'(i * 37 + 5), 8'h00, wt);
    for (int i = 0; i < 40; i++)
      do_cycle(1, 0, 16'(i * 16'h2F11 + 16'h00FF), 8'h00, 8'(~(i * 53)), wt);
    for (int i = 0; i < 24; i++)
      do_cycle(1, i[0], 16'(16'hFFFF - i * 16'h0901), 8'(i * 11), 8'(i * 29 + 1), wt);

    // Idle periods: strobe continues, nothing taken, address repeated (R8)
    do_cycle(0, 0, 16'hDEAD, 8'h00, 8'h00, wt);
    do_cycle(0, 1, 16'hBEEF, 8'h77, 8'h00, wt);
    chk("R8 idle keeps address", mem_addr, last_addr);

    // Read right before a stop: completes in the first halted cycle (R6, R9)
    do_cycle(1, 0, 16'h8001, 8'h00, 8'h5A, wt);
    stop_in = 1;
    req_valid = 1; req_write = 1; req_addr = 16'h4321; req_wdata = 8'h99;
    @(negedge clk);
    chk("R6 read completes on E fall", rd_valid, 1);
    chk("R6 read byte", rd_data, 8'h5A);
    chk("R9 halted e", e_clk, 0);
    chk("R9 halted strobe", as_strobe, 0);
    pend_rd = 0;
    mux_in = 8'hA5;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9 e frozen", e_clk, 0);
      chk("R9 strobe frozen", as_strobe, 0);
      chk("R9 port released", mux_oe, 0);
      chk("R9 no ack while stopped", req_ack, 0);
      chk("R9 address held while stopped", mem_addr, 16'h8001);
    end
    stop_in = 0;
    do_cycle(1, 1, 16'h4321, 8'h99, 8'h00, wt);
    chk("R9 resume on next edge", wt, 1);
    do_cycle(1, 0, 16'h0080, 8'h00, 8'hC3, wt);
    do_cycle(0, 0, 16'h0000, 8'h00, 8'h00, wt);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule